// File: doc/BRIEF.md
# Parallel Port Mode and Direction Configuration

This block holds the write-only setup state for two 8-bit parallel ports, A and B. A host sends bytes over a plain register bus made of a write strobe, a port-select bit and a data byte. The block reads each byte as one of two things. It is either a mode-select word, or the per-pin direction mask that must follow a selection of the bit-wise control mode. The host cannot read any of this state back.

For each port the block drives three things: the operating mode now in force, a per-pin direction vector, and a per-pin output-enable vector for the pad drivers. Port A may also run in bidirectional mode. In that mode its pad enables follow an external drive-enable input, which comes from the data-path handshake logic outside this block.

Top module: `pport_cfg_top`

## Requirements
- R1: After synchronous reset, both ports are in input mode (code 01), their direction vectors are all ones and their output-enable vectors are all zeros.
- R2: When no direction byte is pending, a byte whose bits 3:0 are 1111 selects a mode. Bits 7:6 give the mode: 00 output, 01 input, 10 bidirectional, 11 control. Bits 5:4 have no effect.
- R3: In output mode the output-enable vector is all ones and the direction vector is all zeros. In input mode the output-enable vector is all zeros and the direction vector is all ones.
- R4: Selecting control mode sets that port's direction vector to all ones, so its output-enable vector is all zeros, until a direction byte arrives. This also happens when the port is already in control mode.
- R5: The first write to a port after it selects control mode is loaded as the direction byte, whatever its bits 3:0 are. In that byte, a 1 makes the pin an input and a 0 makes it an output. In control mode the output-enable vector is the bitwise inverse of the direction vector.
- R6: Only one direction byte is taken per control-mode selection. Writes after it are decoded as mode words again.
- R7: When port A is in bidirectional mode, every bit of its output-enable vector equals the drive-enable input, and its direction vector is the inverse of its output-enable vector.
- R8: A mode-select word on port B that asks for bidirectional mode is ignored. Port B keeps its previous mode and direction.
- R9: A write whose bits 3:0 are not 1111 and that is not an awaited direction byte changes nothing.
- R10: A write to one port leaves the other port's mode, direction and pending direction byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle in which it is high |
| wr_port | input | 1 | Port select: 0 selects port A, 1 selects port B |
| wr_data | input | 8 | Written byte |
| a_drive_en | input | 1 | Pad drive enable for port A while it is bidirectional |
| a_mode | output | 2 | Port A mode code (00 out, 01 in, 10 bidir, 11 control) |
| a_dir | output | 8 | Port A per-pin direction, 1 = input |
| a_oe | output | 8 | Port A per-pin output enable |
| b_mode | output | 2 | Port B mode code |
| b_dir | output | 8 | Port B per-pin direction, 1 = input |
| b_oe | output | 8 | Port B per-pin output enable |

## Verification
The decoder is driven with mode words that differ only in bits 5:4, to show that those bits are ignored. It also gets bytes with a low nibble other than 1111, which must change nothing when no direction byte is pending and must be taken as the mask when one is. One mask is a copy of the control-mode word itself, so the test can tell steering by sequence from steering by content. Writes are interleaved across the two ports while a direction byte is pending, so that per-port sequencing can be told apart from a shared pending flag. Bidirectional requests go to both ports, and the drive-enable input is toggled, to separate port A's bidirectional behaviour from port B's refusal of that mode.

// File: rtl/pport_cfg_pkg.sv
package pport_cfg_pkg;

    localparam int BYTE_W     = 8;
    localparam int SEL_LO     = 0;
    localparam int SEL_W      = 4;
    localparam int MODE_LSB   = 6;
    localparam int MODE_W     = 2;
    localparam logic [SEL_W-1:0] MODE_SEL_KEY = 4'b1111;

    typedef enum logic [MODE_W-1:0] {
        PM_OUT   = 2'b00,
        PM_IN    = 2'b01,
        PM_BIDIR = 2'b10,
        PM_CTRL  = 2'b11
    } port_mode_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_MODE = 2'd1,
        CMD_DIR  = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e          kind;
        port_mode_e         mode;
        logic [BYTE_W-1:0]  mask;
    } cfg_cmd_t;

    function automatic logic is_mode_word(input logic [BYTE_W-1:0] b);
        return b[SEL_LO +: SEL_W] == MODE_SEL_KEY;
    endfunction

    function automatic port_mode_e mode_field(input logic [BYTE_W-1:0] b);
        return port_mode_e'(b[MODE_LSB +: MODE_W]);
    endfunction

endpackage

// File: rtl/pport_wr_decode.sv
module pport_wr_decode
    import pport_cfg_pkg::*;
#(
    parameter bit ALLOW_BIDIR = 1'b1
) (
    input  logic              hit,
    input  logic [BYTE_W-1:0] data,
    input  logic              pending,
    output cfg_cmd_t          cmd
);
    port_mode_e req_mode;

    always_comb begin
        req_mode  = mode_field(data);
        cmd.kind  = CMD_NONE;
        cmd.mode  = req_mode;
        cmd.mask  = data;
        if (hit) begin
            if (pending) begin
                cmd.kind = CMD_DIR;
            end else if (is_mode_word(data)) begin
                if (req_mode != PM_BIDIR || ALLOW_BIDIR)
                    cmd.kind = CMD_MODE;
            end
        end
    end
endmodule

// File: rtl/pport_mode_reg.sv
module pport_mode_reg
    import pport_cfg_pkg::*;
#(
    parameter bit ALLOW_BIDIR = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  cfg_cmd_t          cmd,
    output port_mode_e        mode,
    output logic [BYTE_W-1:0] dir_mask,
    output logic              dir_pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode        <= PM_IN;
            dir_mask    <= '1;
            dir_pending <= 1'b0;
        end else begin
            case (cmd.kind)
                CMD_MODE: begin
                    mode <= cmd.mode;
                    if (cmd.mode == PM_CTRL) begin
                        dir_mask    <= '1;
                        dir_pending <= 1'b1;
                    end
                end
                CMD_DIR: begin
                    dir_mask    <= cmd.mask;
                    dir_pending <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    p_pend_entry_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(dir_pending) |-> (mode == PM_CTRL && dir_mask == '1));

    p_pend_once_r6: assert property (@(posedge clk) disable iff (rst)
        (dir_pending && hit) |=> !dir_pending);

    p_no_bidir_r8: assert property (@(posedge clk) disable iff (rst)
        !ALLOW_BIDIR |-> mode != PM_BIDIR);

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !hit |=> ($stable(mode) && $stable(dir_mask) && $stable(dir_pending)));
endmodule

// File: rtl/pport_pad_ctl.sv
module pport_pad_ctl
    import pport_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  port_mode_e        mode,
    input  logic [BYTE_W-1:0] dir_mask,
    input  logic              drive_en,
    output logic [BYTE_W-1:0] oe,
    output logic [BYTE_W-1:0] dir_out
);
    always_comb begin
        unique case (mode)
            PM_OUT: begin
                oe      = '1;
                dir_out = '0;
            end
            PM_IN: begin
                oe      = '0;
                dir_out = '1;
            end
            PM_BIDIR: begin
                oe      = {BYTE_W{drive_en}};
                dir_out = ~{BYTE_W{drive_en}};
            end
            default: begin
                oe      = ~dir_mask;
                dir_out = dir_mask;
            end
        endcase
    end

    p_out_in_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_OUT |-> (oe == '1 && dir_out == '0)) and
        (mode == PM_IN  |-> (oe == '0 && dir_out == '1)));

    p_ctrl_oe_r5: assert property (@(posedge clk) disable iff (rst)
        mode == PM_CTRL |-> (oe & dir_out) == '0);

    p_bidir_r7: assert property (@(posedge clk) disable iff (rst)
        mode == PM_BIDIR |-> (oe == {BYTE_W{drive_en}} && dir_out == ~oe));
endmodule

// File: rtl/pport_cfg_top.sv
module pport_cfg_top
    import pport_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_port,
    input  logic [7:0]        wr_data,
    input  logic              a_drive_en,
    output logic [1:0]        a_mode,
    output logic [7:0]        a_dir,
    output logic [7:0]        a_oe,
    output logic [1:0]        b_mode,
    output logic [7:0]        b_dir,
    output logic [7:0]        b_oe
);
    localparam int NPORTS = 2;

    port_mode_e        mode_q  [NPORTS];
    logic [BYTE_W-1:0] dir_q   [NPORTS];
    logic [BYTE_W-1:0] dir_o   [NPORTS];
    logic [BYTE_W-1:0] oe_o    [NPORTS];
    logic              pend_q  [NPORTS];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam bit BIDIR_OK = (p == 0);
        logic     hit;
        cfg_cmd_t cmd;
        logic     drv;

        assign hit = wr_en && (wr_port == p[0]);
        assign drv = BIDIR_OK ? a_drive_en : 1'b0;

        pport_wr_decode #(.ALLOW_BIDIR(BIDIR_OK)) u_dec (
            .hit     (hit),
            .data    (wr_data),
            .pending (pend_q[p]),
            .cmd     (cmd)
        );

        pport_mode_reg #(.ALLOW_BIDIR(BIDIR_OK)) u_reg (
            .clk         (clk),
            .rst         (rst),
            .hit         (hit),
            .cmd         (cmd),
            .mode        (mode_q[p]),
            .dir_mask    (dir_q[p]),
            .dir_pending (pend_q[p])
        );

        pport_pad_ctl u_pad (
            .clk      (clk),
            .rst      (rst),
            .mode     (mode_q[p]),
            .dir_mask (dir_q[p]),
            .drive_en (drv),
            .oe       (oe_o[p]),
            .dir_out  (dir_o[p])
        );
    end

    assign a_mode = mode_q[0];
    assign a_dir  = dir_o[0];
    assign a_oe   = oe_o[0];
    assign b_mode = mode_q[1];
    assign b_dir  = dir_o[1];
    assign b_oe   = oe_o[1];

    p_isolate_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_port) |=> ($stable(mode_q[0]) && $stable(dir_q[0]) && $stable(pend_q[0])));
endmodule

// File: tb/pport_cfg_top_tb_top.sv
module pport_cfg_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_port = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       a_drive_en = 1'b0;
    logic [1:0] a_mode, b_mode;
    logic [7:0] a_dir, a_oe, b_dir, b_oe;

    always #4 clk = ~clk;

    pport_cfg_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
        .a_drive_en(a_drive_en),
        .a_mode(a_mode), .a_dir(a_dir), .a_oe(a_oe),
        .b_mode(b_mode), .b_dir(b_dir), .b_oe(b_oe)
    );

    typedef struct {
        string      tag;
        logic [1:0] am; logic [7:0] ad; logic [7:0] ao;
        logic [1:0] bm; logic [7:0] bd; logic [7:0] bo;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    logic [1:0] m_mode [2];
    logic [7:0] m_dir  [2];
    bit         m_pend [2];

    function automatic logic [7:0] exp_oe(logic [1:0] m, logic [7:0] d, logic drv);
        case (m)
            2'b00:   return 8'hFF;
            2'b01:   return 8'h00;
            2'b10:   return {8{drv}};
            default: return ~d;
        endcase
    endfunction

    function automatic logic [7:0] exp_dir(logic [1:0] m, logic [7:0] d, logic drv);
        case (m)
            2'b00:   return 8'h00;
            2'b01:   return 8'hFF;
            2'b10:   return ~{8{drv}};
            default: return d;
        endcase
    endfunction

    task automatic push_exp(string tag);
        exp_t e;
        e.tag = tag;
        e.am = m_mode[0]; e.ad = exp_dir(m_mode[0], m_dir[0], a_drive_en);
        e.ao = exp_oe(m_mode[0], m_dir[0], a_drive_en);
        e.bm = m_mode[1]; e.bd = exp_dir(m_mode[1], m_dir[1], 1'b0);
        e.bo = exp_oe(m_mode[1], m_dir[1], 1'b0);
        q.push_back(e);
    endtask

    task automatic wr(int p, logic [7:0] d, string tag);
        @(negedge clk);
        if (m_pend[p]) begin
            m_dir[p]  = d;
            m_pend[p] = 1'b0;
        end else if (d[3:0] == 4'hF) begin
            if (!(d[7:6] == 2'b10 && p == 1)) begin
                m_mode[p] = d[7:6];
                if (d[7:6] == 2'b11) begin
                    m_dir[p]  = 8'hFF;
                    m_pend[p] = 1'b1;
                end
            end
        end
        wr_en   = 1'b1;
        wr_port = p[0];
        wr_data = d;
        push_exp(tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_drv(logic v, string tag);
        @(negedge clk);
        a_drive_en = v;
        push_exp(tag);
    endtask

    // monitor: pops expectations after the edge they belong to
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (a_mode !== e.am || a_dir !== e.ad || a_oe !== e.ao) begin
                    n_errors++;
                    $display("FAIL %s port A: mode=%b dir=%h oe=%h expected mode=%b dir=%h oe=%h",
                             e.tag, a_mode, a_dir, a_oe, e.am, e.ad, e.ao);
                end
                n_checks++;
                if (b_mode !== e.bm || b_dir !== e.bd || b_oe !== e.bo) begin
                    n_errors++;
                    $display("FAIL %s port B: mode=%b dir=%h oe=%h expected mode=%b dir=%h oe=%h",
                             e.tag, b_mode, b_dir, b_oe, e.bm, e.bd, e.bo);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_mode[i] = 2'b01; m_dir[i] = 8'hFF; m_pend[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        push_exp("R1 reset state");

        wr(0, 8'b0000_1111, "R2 R3 port A output");
        wr(0, 8'b0111_1111, "R2 port A input, bits 5:4 set");
        wr(1, 8'b0010_1111, "R2 R3 port B output, bits 5:4=10");
        wr(1, 8'h05,        "R9 port B non-mode byte ignored");
        wr(0, 8'h4E,        "R9 port A nibble 1110 ignored");
        wr(1, 8'hCF,        "R4 port B control entry");
        wr(0, 8'h0F,        "R10 port A write while B pending");
        wr(1, 8'h00,        "R5 port B direction all outputs");
        wr(1, 8'h4F,        "R6 port B decoded as mode again");
        wr(0, 8'hCF,        "R4 port A control entry");
        wr(0, 8'h62,        "R5 port A direction 0x62");
        wr(0, 8'hCF,        "R4 port A control re-entry");
        wr(0, 8'hCF,        "R5 mode-shaped byte taken as direction");
        wr(0, 8'h8F,        "R7 port A bidirectional");
        set_drv(1'b1,       "R7 drive enable high");
        set_drv(1'b0,       "R7 drive enable low");
        wr(1, 8'hCF,        "R4 port B control entry again");
        wr(1, 8'hF0,        "R5 port B direction 0xF0");
        wr(1, 8'h8F,        "R8 port B bidir refused");
        wr(1, 8'hBF,        "R8 port B bidir refused, bits 5:4 set");
        wr(0, 8'h1F,        "R2 port A back to output");
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule